// File: doc/BRIEF.md
# Byte-Window Single-Frame Network Controller

This block is a host-side network controller that keeps exactly one received frame and one outgoing frame, each in its own byte buffer. The host reaches both buffers one byte at a time through a 64-byte register window on a simple synchronous bus. Incoming frames arrive on a byte stream with valid, ready and last. Outgoing frames leave on a byte stream with the same handshake once the host has stored the last byte. One level interrupt line reports completed work.

A single busy flag coordinates the two directions. Any completed transfer sets busy. Busy clears only when the host acknowledges the interrupt status down to zero. While busy is high, no new frame is taken in. Writing the test bit of the interrupt control register restores the reset state and leaves a test interrupt pending. Reading the interrupt control register clears that test interrupt.

Top module: `bytewin_nic`

## Requirements
- R1: After reset: busy reads 1, both counts read 0, interrupt control reads 0, `irq` is low and `rx_ready` is low. A read started with `reg_rd` returns its word on `reg_rdata` one cycle later, and the word stays there until the next read.
- R2: The window is decoded from `reg_addr[5:0]` at these offsets: 0x00 ID word 0, 0x04 ID word 1, 0x08 busy (bit 0), 0x0C receive count, 0x10 transmit count, 0x14 interrupt control, 0x18 interrupt info, 0x1C receive data, 0x20 transmit data. Offset 0x00 reads 0x42595445 and offset 0x04 reads 0x574E4943, which together spell the ASCII text "BYTEWNIC". Offsets 0x18 and 0x20 read 0, and so does any unmapped offset.
- R3: A new frame is accepted only when busy is 0 and the receive count is below 1514. `rx_ready` stays high until the byte flagged with `rx_last` has been taken. When that byte is taken, busy becomes 1, the receive count becomes the frame length, the read position returns to 0 and interrupt bit 1 (receive done) is set.
- R4: Bytes of a frame beyond the 1514th are consumed but discarded, and the stored length is capped at 1514.
- R5: A read of receive data returns the next stored byte in arrival order in bits 7:0 and decrements the receive count. When the count is 0, the read returns 0 and changes nothing.
- R6: A write to the transmit count loads the written value when it is 1514 or less, and loads 0 otherwise. The write also restarts the transmit fill position at 0.
- R7: Each accepted write to transmit data stores bits 7:0. The write that fills the frame to the transmit count does four things: it sends the frame on `tx_data` in order with `tx_last` on the final byte, clears the transmit count, sets interrupt bit 0 (transmit done) and sets busy. Transmit data writes are ignored while the count is 0 or while a frame is still being sent.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold steady.
- R9: A write to interrupt control applies only the first matching case, in this order. Bit 0 set clears transmit done. Otherwise, bit 1 set clears receive done. Otherwise, bit 31 set performs a soft reset to the R1 state and then sets bit 31. Otherwise nothing changes. After the write, busy equals 1 exactly when interrupt control is nonzero.
- R10: A read of interrupt control returns its current value and then clears bit 31.
- R11: `irq` is high exactly when any interrupt control bit is set, and busy is 1 whenever `irq` is high.
- R12: Writes to offsets 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C have no effect.
- R13: When a frame finishes arriving in the same cycle as the host completes an outgoing frame, both done bits are set and both counts take their new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register offset within the window |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| rx_data | input | 8 | Incoming frame byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Controller takes the incoming byte |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
Both the completion of an incoming frame and the host's final transmit data write update the interrupt status and the busy flag, so the two can collide in one cycle. The bench arranges this collision. It stores the first outgoing byte in advance and feeds two non-final receive bytes. It then drives the final receive byte and the last transmit data write on the same clock edge. It then expects interrupt control to read 3, the receive count to equal the frame length, and the queued outgoing bytes to leave with `tx_last` on the second. A second collision, a status read landing in the same cycle as an acknowledge, is judged from the R9 and R10 results that follow.

// File: rtl/bytewin_nic_pkg.sv
package bytewin_nic_pkg;
    localparam logic [5:0] OFF_ID0    = 6'h00;
    localparam logic [5:0] OFF_ID1    = 6'h04;
    localparam logic [5:0] OFF_BUSY   = 6'h08;
    localparam logic [5:0] OFF_RXCNT  = 6'h0C;
    localparam logic [5:0] OFF_TXCNT  = 6'h10;
    localparam logic [5:0] OFF_ICTL   = 6'h14;
    localparam logic [5:0] OFF_INFO   = 6'h18;
    localparam logic [5:0] OFF_RXDATA = 6'h1C;
    localparam logic [5:0] OFF_TXDATA = 6'h20;

    localparam int ICTL_TXDONE = 0;
    localparam int ICTL_RXDONE = 1;
    localparam int ICTL_TEST   = 31;

    localparam logic [31:0] SIG_WORD0 = 32'h4259_5445;
    localparam logic [31:0] SIG_WORD1 = 32'h574E_4943;
endpackage

// File: rtl/bytewin_nic_buf.sv
module bytewin_nic_buf #(
    parameter int DEPTH = 1514,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/bytewin_nic_txq.sv
module bytewin_nic_txq #(
    parameter int CW = 11,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          start,
    input  logic [CW-1:0] len,
    input  logic          ready,
    output logic          valid,
    output logic          last,
    output logic          active,
    output logic [AW-1:0] raddr
);
    typedef struct packed {
        logic          act;
        logic [CW-1:0] idx;
        logic [CW-1:0] len;
    } txq_t;

    txq_t q_q, q_d;
    logic at_end;

    assign at_end = (q_q.idx == q_q.len - CW'(1));

    always_comb begin
        q_d = q_q;
        if (clr) begin
            q_d.act = 1'b0;
        end else if (start) begin
            q_d.act = 1'b1;
            q_d.idx = '0;
            q_d.len = len;
        end else if (q_q.act && ready) begin
            if (at_end) begin
                q_d.act = 1'b0;
            end else begin
                q_d.idx = q_q.idx + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign valid  = q_q.act;
    assign last   = q_q.act && at_end;
    assign active = q_q.act;
    assign raddr  = q_q.idx[AW-1:0];
endmodule

// File: rtl/bytewin_nic.sv
module bytewin_nic
    import bytewin_nic_pkg::*;
#(
    parameter int FRAME_MAX = 1514
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  reg_addr,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);
    localparam int CW = $clog2(FRAME_MAX + 1);
    localparam int AW = $clog2(FRAME_MAX);
    localparam logic [CW-1:0] LIM = CW'(FRAME_MAX);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] rx_cnt;
        logic [CW-1:0] rx_rptr;
        logic [CW-1:0] rx_wcnt;
        logic          rx_cap;
        logic [CW-1:0] tx_cnt;
        logic [CW-1:0] tx_wptr;
        logic [31:0]   intctl;
        logic [31:0]   rdata;
    } nic_st_t;

    localparam nic_st_t RST_ST = '{busy: 1'b1, default: '0};

    nic_st_t st_q, st_d;

    logic          rx_we, rx_fire, rx_room;
    logic [7:0]    rx_rbyte;
    logic          tx_we, tx_start, tx_clr, tx_active;
    logic [AW-1:0] tx_raddr;
    logic          soft_rst;
    logic [31:0]   rd_d;

    assign rx_ready = st_q.rx_cap || (!st_q.busy && (st_q.rx_cnt < LIM));
    assign rx_fire  = rx_valid && rx_ready;
    assign rx_room  = (st_q.rx_wcnt < LIM);

    always_comb begin
        st_d     = st_q;
        rd_d     = st_q.rdata;
        rx_we    = 1'b0;
        tx_we    = 1'b0;
        tx_start = 1'b0;
        tx_clr   = 1'b0;
        soft_rst = 1'b0;

        // host read, with its side effects
        if (reg_rd) begin
            rd_d = '0;
            case (reg_addr)
                OFF_ID0:   rd_d = SIG_WORD0;
                OFF_ID1:   rd_d = SIG_WORD1;
                OFF_BUSY:  rd_d = {31'b0, st_q.busy};
                OFF_RXCNT: rd_d = 32'(st_q.rx_cnt);
                OFF_TXCNT: rd_d = 32'(st_q.tx_cnt);
                OFF_ICTL: begin
                    rd_d = st_q.intctl;
                    st_d.intctl[ICTL_TEST] = 1'b0;
                end
                OFF_RXDATA: begin
                    if (st_q.rx_cnt != '0) begin
                        rd_d = {24'b0, rx_rbyte};
                        st_d.rx_cnt  = st_q.rx_cnt - CW'(1);
                        st_d.rx_rptr = st_q.rx_rptr + CW'(1);
                    end
                end
                default: rd_d = '0;
            endcase
        end

        // host write
        if (reg_wr) begin
            case (reg_addr)
                OFF_TXCNT: begin
                    st_d.tx_cnt  = (reg_wdata <= 32'(FRAME_MAX)) ? reg_wdata[CW-1:0] : '0;
                    st_d.tx_wptr = '0;
                end
                OFF_ICTL: begin
                    if (reg_wdata[ICTL_TXDONE]) begin
                        st_d.intctl[ICTL_TXDONE] = 1'b0;
                    end else if (reg_wdata[ICTL_RXDONE]) begin
                        st_d.intctl[ICTL_RXDONE] = 1'b0;
                    end else if (reg_wdata[ICTL_TEST]) begin
                        st_d = RST_ST;
                        st_d.intctl[ICTL_TEST] = 1'b1;
                        soft_rst = 1'b1;
                        tx_clr   = 1'b1;
                    end
                    st_d.busy = |st_d.intctl;
                end
                OFF_TXDATA: begin
                    if ((st_q.tx_cnt != '0) && !tx_active) begin
                        tx_we = 1'b1;
                        if (st_q.tx_wptr + CW'(1) == st_q.tx_cnt) begin
                            tx_start     = 1'b1;
                            st_d.tx_cnt  = '0;
                            st_d.tx_wptr = '0;
                            st_d.intctl[ICTL_TXDONE] = 1'b1;
                            st_d.busy    = 1'b1;
                        end else begin
                            st_d.tx_wptr = st_q.tx_wptr + CW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end

        // incoming frame capture
        if (rx_fire && !soft_rst) begin
            rx_we = rx_room;
            if (rx_last) begin
                st_d.rx_cnt  = st_q.rx_wcnt + (rx_room ? CW'(1) : CW'(0));
                st_d.rx_rptr = '0;
                st_d.rx_wcnt = '0;
                st_d.rx_cap  = 1'b0;
                st_d.busy    = 1'b1;
                st_d.intctl[ICTL_RXDONE] = 1'b1;
            end else begin
                st_d.rx_cap  = 1'b1;
                st_d.rx_wcnt = st_q.rx_wcnt + (rx_room ? CW'(1) : CW'(0));
            end
        end

        st_d.rdata = rd_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    bytewin_nic_buf #(.DEPTH(FRAME_MAX), .AW(AW)) u_rxbuf (
        .clk   (clk),
        .we    (rx_we),
        .waddr (st_q.rx_wcnt[AW-1:0]),
        .wdata (rx_data),
        .raddr (st_q.rx_rptr[AW-1:0]),
        .rdata (rx_rbyte)
    );

    bytewin_nic_buf #(.DEPTH(FRAME_MAX), .AW(AW)) u_txbuf (
        .clk   (clk),
        .we    (tx_we),
        .waddr (st_q.tx_wptr[AW-1:0]),
        .wdata (reg_wdata[7:0]),
        .raddr (tx_raddr),
        .rdata (tx_data)
    );

    bytewin_nic_txq #(.CW(CW), .AW(AW)) u_txq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tx_clr),
        .start  (tx_start),
        .len    (st_q.tx_cnt),
        .ready  (tx_ready),
        .valid  (tx_valid),
        .last   (tx_last),
        .active (tx_active),
        .raddr  (tx_raddr)
    );

    assign reg_rdata = st_q.rdata;
    assign irq       = |st_q.intctl;
endmodule

// File: rtl/bytewin_nic_chk.sv
module bytewin_nic_chk
    import bytewin_nic_pkg::*;
#(
    parameter int FRAME_MAX = 1514,
    parameter int CW        = $clog2(FRAME_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [5:0]    reg_addr,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [31:0]   reg_rdata,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          rx_last,
    input logic [7:0]    tx_data,
    input logic          tx_valid,
    input logic          tx_last,
    input logic          tx_ready,
    input logic          irq,
    input logic          busy,
    input logic [CW-1:0] rx_cnt
);
    a_r4_rx_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(FRAME_MAX));

    a_r3_ready_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> !busy);

    a_r3_rx_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_last && !(reg_wr && reg_addr == OFF_ICTL))
        |=> (irq && busy));

    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_RXDATA && rx_cnt == '0) |=> (reg_rdata == 32'h0));

    a_r7_single_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !reg_wr) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    a_r11_irq_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy);
endmodule

bind bytewin_nic bytewin_nic_chk #(.FRAME_MAX(FRAME_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_last   (rx_last),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .irq       (irq),
    .busy      (st_q.busy),
    .rx_cnt    (st_q.rx_cnt)
);

// File: tb/tb_bytewin_nic.sv
`timescale 1ns/1ps
module tb_bytewin_nic;
    localparam int LIM = 1514;
    localparam logic [5:0] A_ID0 = 6'h00, A_ID1 = 6'h04, A_BUSY = 6'h08, A_RXC = 6'h0C,
                           A_TXC = 6'h10, A_ICTL = 6'h14, A_INFO = 6'h18, A_RXD = 6'h1C,
                           A_TXD = 6'h20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [5:0] reg_addr = '0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [7:0] rx_data = '0, tx_data;
    logic rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
    logic tx_valid, tx_last, tx_ready = 1'b1, irq;

    int checks = 0, failures = 0;
    logic [8:0] exp_q[$];
    logic stall_en = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    logic prev_stall = 1'b0;
    logic [8:0] prev_out = '0;
    logic [31:0] v;

    always #2 clk = ~clk;

    bytewin_nic dut (.*);

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // driver: pushes expected outgoing bytes into the scoreboard
    task automatic tx_put(logic [7:0] b, logic is_last, logic expect_it);
        if (expect_it) exp_q.push_back({is_last, b});
        wr(A_TXD, {24'h0, b});
    endtask

    task automatic rx_byte(logic [7:0] b, logic l);
        @(negedge clk); rx_data = b; rx_valid = 1'b1; rx_last = l;
        while (!rx_ready) @(negedge clk);
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic rx_frame(int n);
        for (int i = 0; i < n; i++) rx_byte(pat(i), i == n - 1);
    endtask

    task automatic drain();
        for (int i = 0; i < 4000 && (exp_q.size() != 0 || tx_valid); i++) @(negedge clk);
        chk("R7 scoreboard drained", 32'(exp_q.size()), 32'h0);
    endtask

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        #1 tx_ready = stall_en ? lfsr[0] : 1'b1;
    end

    // monitor: pops expected bytes as the design emits them
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                checks++;
                if ({tx_last, tx_data} !== prev_out || !tx_valid) begin
                    failures++;
                    $display("FAIL R8 actual=%h expected=%h", {tx_last, tx_data}, prev_out);
                end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_out   = {tx_last, tx_data};
            if (tx_valid && tx_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R7 actual=%h expected=none", {tx_last, tx_data});
                end else begin
                    automatic logic [8:0] e = exp_q.pop_front();
                    if ({tx_last, tx_data} !== e) begin
                        failures++;
                        $display("FAIL R7 actual=%h expected=%h", {tx_last, tx_data}, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 rx_ready", {31'h0, rx_ready}, 32'h0);
        rd(A_BUSY, v); chk("R1 busy", v, 32'h1);
        rd(A_RXC, v);  chk("R1 rxcnt", v, 32'h0);
        rd(A_TXC, v);  chk("R1 txcnt", v, 32'h0);
        rd(A_ICTL, v); chk("R1 intctl", v, 32'h0);
        // R2 decode
        rd(A_ID0, v);  chk("R2 id0", v, 32'h42595445);
        rd(A_ID1, v);  chk("R2 id1", v, 32'h574E4943);
        rd(A_INFO, v); chk("R2 info", v, 32'h0);
        rd(A_TXD, v);  chk("R2 txdata", v, 32'h0);
        rd(6'h3C, v);  chk("R2 unmapped", v, 32'h0);
        // R12 read-only writes
        wr(A_BUSY, 32'h0); wr(A_RXC, 32'h55); wr(A_ID0, 32'h0); wr(A_INFO, 32'h7); wr(A_RXD, 32'h9);
        rd(A_BUSY, v); chk("R12 busy kept", v, 32'h1);
        rd(A_RXC, v);  chk("R12 rxcnt kept", v, 32'h0);
        rd(A_ID0, v);  chk("R12 id kept", v, 32'h42595445);
        // R9 zero write clears busy
        wr(A_ICTL, 32'h0);
        rd(A_BUSY, v); chk("R9 busy after zero ack", v, 32'h0);
        chk("R3 ready when idle", {31'h0, rx_ready}, 32'h1);
        // R3 receive
        rx_frame(5);
        chk("R3 ready drops", {31'h0, rx_ready}, 32'h0);
        chk("R11 irq on rx", {31'h0, irq}, 32'h1);
        rd(A_RXC, v);  chk("R3 rxcnt", v, 32'd5);
        rd(A_ICTL, v); chk("R3 rxdone", v, 32'h2);
        rd(A_BUSY, v); chk("R3 busy", v, 32'h1);
        // R5 readout
        for (int i = 0; i < 5; i++) begin
            rd(A_RXD, v); chk("R5 rx byte", v, {24'h0, pat(i)});
        end
        rd(A_RXC, v); chk("R5 count drained", v, 32'h0);
        rd(A_RXD, v); chk("R5 empty read", v, 32'h0);
        rd(A_RXC, v); chk("R5 count stays", v, 32'h0);
        wr(A_ICTL, 32'h2);
        rd(A_ICTL, v); chk("R9 rx ack", v, 32'h0);
        chk("R11 irq low", {31'h0, irq}, 32'h0);
        // R6 / R7 transmit
        stall_en = 1'b1;
        tx_put(8'hEE, 1'b0, 1'b0);
        rd(A_TXC, v); chk("R7 write ignored at zero count", v, 32'h0);
        wr(A_TXC, 32'd2000);
        rd(A_TXC, v); chk("R6 oversize count", v, 32'h0);
        wr(A_TXC, 32'd1514);
        rd(A_TXC, v); chk("R6 max count", v, 32'd1514);
        wr(A_TXC, 32'd4);
        tx_put(8'h11, 1'b0, 1'b0); tx_put(8'h22, 1'b0, 1'b0);
        wr(A_TXC, 32'd3);
        tx_put(8'hA1, 1'b0, 1'b1); tx_put(8'hB2, 1'b0, 1'b1); tx_put(8'hC3, 1'b1, 1'b1);
        tx_put(8'h99, 1'b0, 1'b0);
        rd(A_TXC, v);  chk("R7 count cleared", v, 32'h0);
        rd(A_ICTL, v); chk("R7 txdone", v, 32'h1);
        rd(A_BUSY, v); chk("R7 busy", v, 32'h1);
        drain();
        wr(A_ICTL, 32'h1);
        rd(A_BUSY, v); chk("R9 tx ack busy", v, 32'h0);
        // R13 coincident completions
        wr(A_TXC, 32'd2);
        tx_put(8'h5A, 1'b0, 1'b1);
        rx_byte(pat(0), 1'b0); rx_byte(pat(1), 1'b0);
        @(negedge clk);
        chk("R13 ready in capture", {31'h0, rx_ready}, 32'h1);
        rx_data = pat(2); rx_valid = 1'b1; rx_last = 1'b1;
        reg_addr = A_TXD; reg_wdata = 32'hA5; reg_wr = 1'b1; exp_q.push_back({1'b1, 8'hA5});
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0; reg_wr = 1'b0;
        rd(A_ICTL, v); chk("R13 both done", v, 32'h3);
        rd(A_RXC, v);  chk("R13 rxcnt", v, 32'd3);
        rd(A_TXC, v);  chk("R13 txcnt", v, 32'h0);
        drain();
        // R9 priority
        wr(A_ICTL, 32'h3);
        rd(A_ICTL, v); chk("R9 bit0 first", v, 32'h2);
        rd(A_BUSY, v); chk("R9 busy kept", v, 32'h1);
        wr(A_ICTL, 32'h8000_0002);
        rd(A_ICTL, v); chk("R9 bit1 before test", v, 32'h0);
        rd(A_RXC, v);  chk("R9 no reset", v, 32'd3);
        wr(A_ICTL, 32'h8000_0000);
        chk("R11 irq test", {31'h0, irq}, 32'h1);
        rd(A_RXC, v);  chk("R9 soft reset rxcnt", v, 32'h0);
        rd(A_BUSY, v); chk("R9 soft reset busy", v, 32'h1);
        // R10 read clears test bit
        rd(A_ICTL, v); chk("R10 first read", v, 32'h8000_0000);
        rd(A_ICTL, v); chk("R10 second read", v, 32'h0);
        chk("R11 irq cleared", {31'h0, irq}, 32'h0);
        wr(A_ICTL, 32'h0);
        // R4 oversize frame
        stall_en = 1'b0;
        rx_frame(LIM + 2);
        rd(A_RXC, v); chk("R4 capped", v, 32'd1514);
        wr(A_ICTL, 32'h2);
        chk("R3 full count blocks", {31'h0, rx_ready}, 32'h0);
        begin
            automatic int bad = 0;
            for (int i = 0; i < LIM; i++) begin
                rd(A_RXD, v);
                if (v !== {24'h0, pat(i)}) bad++;
            end
            chk("R4 stored bytes mismatches", 32'(bad), 32'h0);
        end
        rd(A_RXC, v); chk("R5 drained after cap", v, 32'h0);
        chk("R3 ready again", {31'h0, rx_ready}, 32'h1);
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule